// File: doc/BRIEF.md
# Slow-Clock Seconds Timer

This block is a free-running elapsed-time counter for an always-on power domain. Its own clock is the slow clock. A programmable divider turns that clock into a periodic tick, and each tick advances an up-counter. With the divider set equal to the slow-clock frequency, the counter counts seconds. Software may restart the counter from zero at any time but can never load it with a value. A software time base kept elsewhere turns the count into wall-clock time.

A compare register raises an alarm flag when the counter reaches a chosen value. Every tick also raises a tick flag. Both flags stay set until software reads the status word, and that read clears them. Each flag has its own enable onto a single interrupt line. All access goes through a small register bus with one-cycle write and read strobes. Read data is combinational from the address.

Top module: `sec_timer`

## Requirements
- R1: After reset the control word reads the reset divider value (parameter, default 0x8000) with both enables at 0. The compare word reads all ones at the counter width, and the count, the status word and `irq` all read 0.
- R2: The count advances by exactly one every P clock cycles, where P is the divider field (control word bits [15:0]) for values 1 to 65535. A field value of 0 gives a period of 65536 cycles.
- R3: A control-word write (offset 0x00) with bit 18 set does three things on that write's edge. It zeroes the divider phase and the count, and it loads the divider field and the enables from the same write. Bit 18 always reads back 0. A control-word write with bit 18 clear leaves the count and the divider phase alone.
- R4: The count word (offset 0x08) is read-only. A write to it changes nothing.
- R5: The tick flag (status bit 1, offset 0x0C) sets on every count advance. A read strobe on the status word returns the flags and clears both of them on that edge. If a flag's event falls on the same edge as the clearing read, the flag stays set.
- R6: The alarm flag (status bit 0) sets on the tick whose advance makes the count equal to the compare word (offset 0x04). A restart to zero never sets it, even when the compare word is 0.
- R7: `irq` is high exactly when (alarm flag AND control bit 16) OR (tick flag AND control bit 17).
- R8: The count wraps from all ones to zero on a tick. The count and compare widths are a parameter, and reads zero-extend them to 32 bits.
- R9: Word offsets above 0x0C, and any byte address whose two low bits are not zero, read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; only matters for the clear-on-read status word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt: enabled flags ORed |

## Verification
The bench runs a reduced 8-bit counter so that wrap-around can be reached. It sweeps several small divider values cycle by cycle and compares the count with floor(n/P), so a divider that is off by one drifts out within a few periods. One status read is timed onto a tick edge, which catches a design that lets the clear beat the new event and loses that tick. A compare value of 0 is used across a restart and across the wrap: a design that matches on any counter change fires early, and a design that compares the old count fires one tick late. Strobes to misaligned and out-of-range addresses check that a partial address decode cannot alias onto the control or compare registers.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

  // Divider field width; the control-word bit layout below depends on it.
  localparam int unsigned PRE_W = 16;

  // Control-word bit positions.
  localparam int unsigned BIT_ALM_IE  = 16;
  localparam int unsigned BIT_TICK_IE = 17;
  localparam int unsigned BIT_RESTART = 18;

  // Status-word bit positions (also index the flag vector).
  localparam int unsigned ST_ALM  = 0;
  localparam int unsigned ST_TICK = 1;
  localparam int unsigned N_FLAGS = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CMP    = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/sec_timer_divider.sv
module sec_timer_divider
  import sec_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] period_sel,
  output logic             tick
);

  localparam int unsigned PW = PRE_W + 1;

  logic [PRE_W-1:0] phase_q, phase_d;
  logic [PW-1:0]    period;
  logic [PW-1:0]    last_phase;
  logic             at_last;

  // A zero field means the full 2^PRE_W period.
  always_comb begin
    period = {1'b0, period_sel};
    if (period_sel == '0) begin
      period = {1'b1, {PRE_W{1'b0}}};
    end
    last_phase = period - PW'(1);
  end

  assign at_last = ({1'b0, phase_q} == last_phase);
  assign tick    = at_last && !restart;

  always_comb begin
    phase_d = phase_q + PRE_W'(1);
    if (restart || at_last) begin
      phase_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // R2: a tick always starts a fresh period.
  p_tick_rephase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q == '0));

  // R3: a restart zeroes the divider phase.
  p_restart_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));

endmodule

// File: rtl/sec_timer_counter.sv
module sec_timer_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             cmp_hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_plus;
  logic             cnt_en;

  // Natural modulo-2^CNT_W wrap.
  assign cnt_plus = cnt_q + CNT_W'(1);
  assign cnt_en   = tick || restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_plus;
    end
  end

  // Compare against the value the count is about to take.
  assign cmp_hit = tick && (cnt_plus == cmp_val);
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q));

  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  p_hit_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> (cnt_q == $past(cmp_val)));

endmodule

// File: rtl/sec_timer_flags.sv
module sec_timer_flags
  import sec_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] evt,
  input  logic               rd_clear,
  input  logic [N_FLAGS-1:0] irq_en,
  output logic [N_FLAGS-1:0] flags,
  output logic               irq
);

  logic [N_FLAGS-1:0] flag_q, flag_d;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    // A new event outranks the clearing read.
    always_comb begin
      flag_d[g] = flag_q[g];
      if (evt[g]) begin
        flag_d[g] = 1'b1;
      end else if (rd_clear) begin
        flag_d[g] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= flag_d[g];
      end
    end

    p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flag_q[g]);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !evt[g]) |=> !flag_q[g]);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !rd_clear) |=> flag_q[g]);
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & irq_en);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != '0));

endmodule

// File: rtl/sec_timer.sv
module sec_timer
  import sec_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter logic [15:0] RESET_PRESC = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  // ---------------- address decode ----------------
  logic     addr_ok;
  reg_sel_e sel;
  logic     wr_ctrl, wr_cmp, wr_count, rd_status, restart;

  assign addr_ok   = (bus_addr[ADDR_W-1:4] == '0) && (bus_addr[1:0] == 2'b00);
  assign sel       = reg_sel_e'(bus_addr[3:2]);
  assign wr_ctrl   = bus_wr && addr_ok && (sel == REG_CTRL);
  assign wr_cmp    = bus_wr && addr_ok && (sel == REG_CMP);
  assign wr_count  = bus_wr && addr_ok && (sel == REG_COUNT);
  assign rd_status = bus_rd && addr_ok && (sel == REG_STATUS);
  assign restart   = wr_ctrl && bus_wdata[BIT_RESTART];

  // ---------------- configuration registers ----------------
  logic [PRE_W-1:0] presc_q, presc_d;
  logic             alm_ie_q, alm_ie_d;
  logic             tick_ie_q, tick_ie_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;

  always_comb begin
    presc_d   = presc_q;
    alm_ie_d  = alm_ie_q;
    tick_ie_d = tick_ie_q;
    cmp_d     = cmp_q;
    if (wr_ctrl) begin
      presc_d   = bus_wdata[PRE_W-1:0];
      alm_ie_d  = bus_wdata[BIT_ALM_IE];
      tick_ie_d = bus_wdata[BIT_TICK_IE];
    end
    if (wr_cmp) begin
      cmp_d = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      presc_q   <= RESET_PRESC;
      alm_ie_q  <= 1'b0;
      tick_ie_q <= 1'b0;
    end else if (wr_ctrl) begin
      presc_q   <= presc_d;
      alm_ie_q  <= alm_ie_d;
      tick_ie_q <= tick_ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmp_q <= '1;
    end else if (wr_cmp) begin
      cmp_q <= cmp_d;
    end
  end

  // ---------------- datapath ----------------
  logic               tick;
  logic [CNT_W-1:0]   count;
  logic               cmp_hit;
  logic [N_FLAGS-1:0] evt, irq_en, flags;

  sec_timer_divider u_div (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .restart    (restart),
    .period_sel (presc_q),
    .tick       (tick)
  );

  sec_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick),
    .restart (restart),
    .cmp_val (cmp_q),
    .count   (count),
    .cmp_hit (cmp_hit)
  );

  always_comb begin
    evt             = '0;
    evt[ST_ALM]     = cmp_hit;
    evt[ST_TICK]    = tick;
    irq_en          = '0;
    irq_en[ST_ALM]  = alm_ie_q;
    irq_en[ST_TICK] = tick_ie_q;
  end

  sec_timer_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .evt      (evt),
    .rd_clear (rd_status),
    .irq_en   (irq_en),
    .flags    (flags),
    .irq      (irq)
  );

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      unique case (sel)
        REG_CTRL: begin
          bus_rdata[PRE_W-1:0]   = presc_q;
          bus_rdata[BIT_ALM_IE]  = alm_ie_q;
          bus_rdata[BIT_TICK_IE] = tick_ie_q;
        end
        REG_CMP:    bus_rdata[CNT_W-1:0]   = cmp_q;
        REG_COUNT:  bus_rdata[CNT_W-1:0]   = count;
        REG_STATUS: bus_rdata[N_FLAGS-1:0] = flags;
        default:    bus_rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_count_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_count && !tick && !restart) |=> $stable(count));

  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && !addr_ok) |=> ($stable(presc_q) && $stable(cmp_q)
                              && $stable(alm_ie_q) && $stable(tick_ie_q)));

  p_restart_no_alarm_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (restart && !flags[ST_ALM]) |=> !flags[ST_ALM]);

endmodule

// File: tb/sec_timer_bench.sv
module sec_timer_bench;

  localparam int unsigned CW = 8;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  sec_timer #(.CNT_W(CW), .ADDR_W(AW), .RESET_PRESC(16'h8000)) u_sec_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #5ns clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act=%0d expected<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [AW-1:0] A_CTRL = 6'h00;
  localparam logic [AW-1:0] A_CMP  = 6'h04;
  localparam logic [AW-1:0] A_CNT  = 6'h08;
  localparam logic [AW-1:0] A_STAT = 6'h0C;

  function automatic logic [31:0] ctrl(input int p, input bit aie, input bit tie, input bit rs);
    return {13'b0, rs, tie, aie, 16'(p)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Freeze ticking with the longest period, then clear the flags.
  task automatic quiesce();
    logic [31:0] d;
    wr(A_CTRL, ctrl(0, 0, 0, 1));
    rd(A_STAT, d);
  endtask

  initial begin
    logic [31:0] d;
    int p;

    step(3);
    rst_n = 1'b1;
    step(4);

    // R1: reset state
    peek(A_CTRL, d); chk("R1 ctrl", d, 32'h0000_8000);
    peek(A_CMP, d);  chk("R1 cmp", d, 32'h0000_00FF);
    peek(A_STAT, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R9: unmapped and misaligned accesses
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h06, 32'h0000_0000);
    wr(6'h21, 32'hFFFF_FFFF);
    peek(A_CTRL, d); chk("R9 ctrl untouched", d, 32'h0000_8000);
    peek(A_CMP, d);  chk("R9 cmp untouched", d, 32'h0000_00FF);
    peek(6'h14, d);  chk("R9 read 0x14", d, 32'h0);
    peek(6'h06, d);  chk("R9 read misaligned", d, 32'h0);
    peek(6'h3C, d);  chk("R9 read 0x3C", d, 32'h0);

    // R2/R3/R5/R6: divider sweep with compare value 2
    foreach (p_list[i]) begin
      p = p_list[i];
      quiesce();
      wr(A_CMP, 32'd2);
      wr(A_CTRL, ctrl(p, 0, 0, 1));
      peek(A_CTRL, d); chk("R3 restart bit reads 0", d, ctrl(p, 0, 0, 0));
      peek(A_CNT, d);  chk("R3 count zero after restart", d, 32'h0);
      for (int n = 1; n <= 3 * p + 1; n++) begin
        step(1);
        peek(A_CNT, d);  chk("R2 count=floor(n/P)", d, 32'(n / p));
        peek(A_STAT, d);
        chk("R5 tick flag", {31'b0, d[1]}, {31'b0, (n >= p)});
        chk("R6 alarm flag", {31'b0, d[0]}, {31'b0, ((n / p) >= 2)});
      end
    end

    // R5: clearing read lands on a tick edge; the event wins
    quiesce();
    wr(A_CTRL, ctrl(4, 0, 0, 1));
    step(3);
    rd(A_STAT, d);   chk("R5 read before tick", d, 32'h0);
    peek(A_STAT, d); chk("R5 tick kept over clear", d, 32'h2);
    rd(A_STAT, d);   chk("R5 read returns flag", d, 32'h2);
    peek(A_STAT, d); chk("R5 read clears", d, 32'h0);

    // R7: interrupt gating; R3 write without restart; R4 read-only count
    quiesce();
    wr(A_CMP, 32'd3);
    wr(A_CTRL, ctrl(2, 1, 0, 1));
    step(2);
    chk("R7 tick flag masked", {31'b0, irq}, 32'h0);
    step(4);
    chk("R7 alarm raises irq", {31'b0, irq}, 32'h1);
    rd(A_STAT, d);   chk("R6 alarm and tick flags", d, 32'h3);
    chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(A_CTRL, ctrl(2, 0, 1, 0));
    chk("R7 tick enable raises irq", {31'b0, irq}, 32'h1);
    peek(A_CNT, d);  chk("R3 no restart keeps count", d, 32'd4);
    wr(A_CNT, 32'h0000_0055);
    peek(A_CNT, d);  chk("R4 count write ignored", d, 32'd4);

    // R8/R6: wrap with compare 0
    quiesce();
    wr(A_CMP, 32'd0);
    wr(A_CTRL, ctrl(1, 0, 0, 1));
    peek(A_STAT, d); chk("R6 restart does not match 0", d, 32'h0);
    step(255);
    peek(A_CNT, d);  chk("R8 count at max", d, 32'd255);
    peek(A_STAT, d); chk("R6 no alarm before wrap", {31'b0, d[0]}, 32'h0);
    step(1);
    peek(A_CNT, d);  chk("R8 wrap to zero", d, 32'd0);
    peek(A_STAT, d); chk("R6 alarm on wrap", {31'b0, d[0]}, 32'h1);
    step(1);
    peek(A_CNT, d);  chk("R8 count after wrap", d, 32'd1);

    // R2: zero divider field means 65536 cycles
    wr(A_CTRL, ctrl(0, 0, 0, 1));
    step(65535);
    peek(A_CNT, d);  chk("R2 zero field no tick yet", d, 32'd0);
    step(1);
    peek(A_CNT, d);  chk("R2 zero field one tick", d, 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int p_list [5] = '{1, 2, 3, 5, 7};

endmodule